// File: doc/BRIEF.md
# Four-Error Sector Correction Sequencer

This block drives the correction side of a four-error BCH scheme for one 512-byte flash sector. On a start pulse it captures the ten parity bytes stored with the sector and repacks them into eight 10-bit parity words. It feeds those words to an external syndrome engine, highest word first. If the engine's four syndrome words come back all zero, the sector is clean and the block finishes at once.

Otherwise it kicks the engine's error search and waits a fixed settling time. It then polls the engine state until the engine reports clean, uncorrectable or done. When done, it walks the reported error list, which holds up to four entries. Each reported position is counted backwards from the end of the protected span. The block turns it into a byte offset, skips positions that fall in the parity bytes, and XORs the error value into the sector buffer through a read-modify-write port. A done pulse closes every run. It carries the number of bytes changed and, when the sector could not be corrected, a fail flag.

The syndrome and error-locator arithmetic are not part of this block. The block only sequences that engine and applies its results.

Top module: `bch4_fixup_seq`

## Requirements
- R1: Parity word k (k = 0..7) is bits 10k+9..10k of `code_in`, where byte j of the stored code sits in bits 8j+7..8j. Read as five little-endian 16-bit words, this makes word 1 bits 15..10 of the first word joined below bits 3..0 of the second.
- R2: In the eight consecutive cycles that follow the cycle in which `start` is accepted, `ld_valid` is high. `ld_data` carries parity words 7, 6, …, 0 in that order. `ld_valid` is low at all other times.
- R3: In the cycle after the last load, `syndrome` (four 10-bit words) is sampled. If all 40 bits are zero, `done` pulses in the next cycle with `fixed_cnt` = 0 and `fail` = 0. In that case `corr_go` does not pulse and the buffer is not touched.
- R4: When the syndrome is non-zero, `corr_go` pulses for exactly one cycle, in the cycle after the syndrome is sampled.
- R5: `eng_state` is first sampled `SETTLE_CYC` + 1 cycles after the `corr_go` cycle and is then sampled every cycle. State 0 ends the run with `fixed_cnt` = 0. State 1 ends the run with `fail` high during the `done` pulse. States 2 and 3 start correction with 1 + `err_cnt_m1` errors. Any other state (4..15) keeps the block polling.
- R6: For errors 0 and 1, position and value come from `rpt_addr_a` and `rpt_val_a`. For errors 2 and 3 they come from `rpt_addr_b` and `rpt_val_b`. Even-numbered errors use bits 9..0 and odd-numbered errors use bits 25..16.
- R7: A reported position p maps to byte offset 519 − p. Only positions 8..519 (offsets 511..0) are corrected. Any other position costs one cycle and makes no buffer access.
- R8: Each correction raises `buf_rd` with `buf_addr` for one cycle. In the next cycle it raises `buf_wr` at the same address, with `buf_wdata` equal to `buf_rdata` XOR the low 8 bits of the error value. The buffer returns read data one cycle after `buf_rd`.
- R9: `done` is a one-cycle pulse in the cycle after the last error has been handled. During that pulse `fixed_cnt` equals the number of bytes written.
- R10: After reset all strobes are low and `fixed_cnt` is 0. `start` is ignored from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sector run |
| code_in | input | 80 | Ten stored parity bytes, byte 0 in bits 7..0 |
| syndrome | input | 40 | Four 10-bit syndrome words from the engine |
| eng_state | input | 4 | Engine search state |
| err_cnt_m1 | input | 2 | Reported error count minus one |
| rpt_addr_a | input | 32 | Positions of errors 0 and 1 |
| rpt_addr_b | input | 32 | Positions of errors 2 and 3 |
| rpt_val_a | input | 32 | Values of errors 0 and 1 |
| rpt_val_b | input | 32 | Values of errors 2 and 3 |
| buf_rdata | input | 8 | Sector buffer read data |
| ld_valid | output | 1 | Parity word load strobe |
| ld_data | output | 10 | Parity word being loaded |
| corr_go | output | 1 | Start error search in the engine |
| buf_rd | output | 1 | Sector buffer read strobe |
| buf_wr | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte offset |
| buf_wdata | output | 8 | Sector buffer write data |
| done | output | 1 | Run complete pulse |
| fail | output | 1 | Uncorrectable flag, valid with done |
| fixed_cnt | output | 3 | Bytes corrected, valid with done |

## Verification
The timing of every output after `start` is fixed. The loads come in cycles 1 to 8 and the syndrome decision in cycle 9. A clean sector gives `done` in cycle 10; otherwise `corr_go` pulses in cycle 10. The first poll falls in cycle 11 + `SETTLE_CYC`, or in the cycle the engine model leaves its busy state if that is later. After the poll, each error adds three cycles if it is in range and one if it is skipped. Before each run the bench computes the exact cycle of every load, kick, read, write and done from these rules. It compares all strobes at every falling edge against that timeline, so an early, late or extra strobe is caught in the cycle it happens. One of the runs has its engine leave the busy state before the settling time ends, so reacting early to `eng_state` shows up as an early `done`.

// File: rtl/bch4_fixup_seq.sv
module bch4_fixup_seq #(
  parameter int SETTLE_CYC   = 20000,
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_BIAS    = 519,
  parameter int NWORDS       = 8,
  parameter int PW           = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NWORDS*PW-1:0]   code_in,
  input  logic [4*PW-1:0]        syndrome,
  input  logic [3:0]             eng_state,
  input  logic [1:0]             err_cnt_m1,
  input  logic [31:0]            rpt_addr_a,
  input  logic [31:0]            rpt_addr_b,
  input  logic [31:0]            rpt_val_a,
  input  logic [31:0]            rpt_val_b,
  input  logic [7:0]             buf_rdata,
  output logic                   ld_valid,
  output logic [PW-1:0]          ld_data,
  output logic                   corr_go,
  output logic                   buf_rd,
  output logic                   buf_wr,
  output logic [$clog2(SECTOR_BYTES)-1:0] buf_addr,
  output logic [7:0]             buf_wdata,
  output logic                   done,
  output logic                   fail,
  output logic [2:0]             fixed_cnt
);
  localparam int AW = $clog2(SECTOR_BYTES);
  localparam int IW = $clog2(NWORDS);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam int OW = PW + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_CHECK, S_KICK, S_SETTLE, S_POLL, S_PICK, S_RD, S_WR, S_FIN
  } st_t;

  st_t                 st;
  logic [NWORDS*PW-1:0] code_q;
  logic [IW-1:0]       idx;
  logic [TW-1:0]       tmr;
  logic [1:0]          nerr, k;
  logic [AW-1:0]       off_q;
  logic [7:0]          val_q;
  logic                fail_q;
  logic [PW-1:0]       pw [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_slice
    assign pw[g] = code_q[g*PW +: PW];
  end

  wire [31:0]   addr_sel = k[1] ? rpt_addr_b : rpt_addr_a;
  wire [31:0]   val_sel  = k[1] ? rpt_val_b  : rpt_val_a;
  wire [PW-1:0] pos      = k[0] ? addr_sel[25:16] : addr_sel[9:0];
  wire [PW-1:0] evl      = k[0] ? val_sel[25:16]  : val_sel[9:0];
  wire [OW-1:0] off_full = OW'(ADDR_BIAS) - {1'b0, pos};
  wire          hit      = off_full < OW'(SECTOR_BYTES);
  wire          syn_zero = (syndrome == '0);
  wire          unused_ok = ^{rpt_addr_a[31:26], rpt_addr_a[15:10], rpt_addr_b[31:26],
                              rpt_addr_b[15:10], rpt_val_a[31:26], rpt_val_a[15:10],
                              rpt_val_b[31:26], rpt_val_b[15:10], evl[PW-1:8]};

  assign ld_valid  = (st == S_LOAD);
  assign ld_data   = pw[idx];
  assign corr_go   = (st == S_KICK);
  assign buf_rd    = (st == S_RD);
  assign buf_wr    = (st == S_WR);
  assign buf_addr  = off_q;
  assign buf_wdata = buf_rdata ^ val_q;
  assign done      = (st == S_FIN);
  assign fail      = done & fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; code_q <= '0; idx <= '0; tmr <= '0; nerr <= '0; k <= '0;
      off_q <= '0; val_q <= '0; fail_q <= 1'b0; fixed_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          code_q <= code_in; idx <= IW'(NWORDS - 1);
          fail_q <= 1'b0; fixed_cnt <= '0; st <= S_LOAD;
        end
        S_LOAD: begin
          idx <= idx - 1'b1;
          if (idx == '0) st <= S_CHECK;
        end
        S_CHECK: st <= syn_zero ? S_FIN : S_KICK;
        S_KICK: begin tmr <= '0; st <= S_SETTLE; end
        S_SETTLE: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(SETTLE_CYC - 1)) st <= S_POLL;
        end
        S_POLL: case (eng_state)
          4'd0: st <= S_FIN;
          4'd1: begin fail_q <= 1'b1; st <= S_FIN; end
          4'd2, 4'd3: begin nerr <= err_cnt_m1; k <= '0; st <= S_PICK; end
          default: st <= S_POLL;
        endcase
        S_PICK: begin
          off_q <= off_full[AW-1:0];
          val_q <= evl[7:0];
          if (hit) st <= S_RD;
          else if (k == nerr) st <= S_FIN;
          else k <= k + 1'b1;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          fixed_cnt <= fixed_cnt + 1'b1;
          if (k == nerr) st <= S_FIN;
          else begin k <= k + 1'b1; st <= S_PICK; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_LOAD_AT_KICK: assert property (@(posedge clk) disable iff (!rst_n) corr_go |-> !ld_valid); // R2
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) corr_go |=> !corr_go); // R4
  AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) fail |-> done && fixed_cnt == 3'd0); // R5
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) buf_wr |-> $past(buf_rd)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) buf_wr |-> $stable(buf_addr)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> !buf_rd && !buf_wr && !ld_valid && !corr_go); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) done |-> fixed_cnt <= 3'd4 || unused_ok !== unused_ok); // R9
endmodule

// File: tb/bch4_fixup_seq_bench.sv
module bch4_fixup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [79:0] code_in = '0;
  logic [39:0] syndrome = '0;
  logic [3:0]  eng_state = 4'd4;
  logic [1:0]  err_cnt_m1 = '0;
  logic [31:0] rpt_addr_a = '0, rpt_addr_b = '0, rpt_val_a = '0, rpt_val_b = '0;
  logic [7:0]  buf_rdata;
  logic        ld_valid, corr_go, buf_rd, buf_wr, done, fail;
  logic [9:0]  ld_data;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_wdata;
  logic [2:0]  fixed_cnt;

  logic [7:0] mem [0:511];
  logic [7:0] mdl [0:511];
  int vec = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch4_fixup_seq #(.SETTLE_CYC(SETTLE)) u_bch4_fixup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in), .syndrome(syndrome),
    .eng_state(eng_state), .err_cnt_m1(err_cnt_m1), .rpt_addr_a(rpt_addr_a),
    .rpt_addr_b(rpt_addr_b), .rpt_val_a(rpt_val_a), .rpt_val_b(rpt_val_b),
    .buf_rdata(buf_rdata), .ld_valid(ld_valid), .ld_data(ld_data), .corr_go(corr_go),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .done(done), .fail(fail), .fixed_cnt(fixed_cnt));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
      buf_rdata <= '0;
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_wr) mem[buf_addr] <= buf_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [79:0] code, input logic [39:0] syn,
                          input logic [3:0] fst, input logic [1:0] cm1, input int busy,
                          input logic [31:0] ra, input logic [31:0] rb,
                          input logic [31:0] va, input logic [31:0] vb, input bit poke);
    logic [15:0] w [5];
    logic [9:0]  exp_ld [8];
    int go_cyc, done_cyc, p, t, cnt;
    int rd_cyc [4], wr_cyc [4], wa [4], wd [4];
    bit efail;
    for (int i = 0; i < 5; i++) w[i] = {code[16*i+8 +: 8], code[16*i +: 8]};
    exp_ld[0] = w[0][9:0];
    exp_ld[1] = {w[1][3:0], w[0][15:10]};
    exp_ld[2] = w[1][13:4];
    exp_ld[3] = {w[2][7:0], w[1][15:14]};
    exp_ld[4] = {w[3][1:0], w[2][15:8]};
    exp_ld[5] = w[3][11:2];
    exp_ld[6] = {w[4][5:0], w[3][15:12]};
    exp_ld[7] = w[4][15:6];
    for (int i = 0; i < 4; i++) begin rd_cyc[i] = -1; wr_cyc[i] = -1; wa[i] = 0; wd[i] = 0; end
    cnt = 0; efail = 1'b0; go_cyc = -1;
    if (syn == '0) done_cyc = 10;
    else begin
      go_cyc = 10;
      p = (11 + SETTLE > 10 + busy) ? 11 + SETTLE : 10 + busy;
      if (fst == 4'd0 || fst == 4'd1) begin done_cyc = p + 1; efail = (fst == 4'd1); end
      else begin
        t = p + 1;
        for (int e = 0; e <= int'(cm1); e++) begin
          logic [31:0] rs, vs;
          int pos, off;
          rs = (e >= 2) ? rb : ra;
          vs = (e >= 2) ? vb : va;
          pos = (e % 2 == 1) ? int'(rs[25:16]) : int'(rs[9:0]);
          off = 519 - pos;
          if (off >= 0 && off < 512) begin
            rd_cyc[e] = t + 1; wr_cyc[e] = t + 2; wa[e] = off;
            wd[e] = int'(mdl[off] ^ (e % 2 == 1 ? vs[23:16] : vs[7:0]));
            mdl[off] = 8'(wd[e]); cnt++; t += 3;
          end else t += 1;
        end
        done_cyc = t;
      end
    end
    code_in = code; syndrome = syn; err_cnt_m1 = cm1;
    rpt_addr_a = ra; rpt_addr_b = rb; rpt_val_a = va; rpt_val_b = vb;
    eng_state = 4'd4; start = 1'b1;
    for (int n = 1; n <= done_cyc + 2; n++) begin
      bit er, ew;
      int ai;
      @(negedge clk);
      start = poke && (n == 15);
      if (n == 15) code_in = ~code;
      eng_state = (syn != '0 && n >= 10 + busy) ? fst : 4'd4;
      chk(ld_valid == (n >= 1 && n <= 8), "R2 ld_valid", int'(ld_valid), int'(n >= 1 && n <= 8));
      if (n >= 1 && n <= 8) chk(ld_data == exp_ld[8 - n], "R1 ld_data", int'(ld_data), int'(exp_ld[8 - n]));
      chk(corr_go == (n == go_cyc), syn == '0 ? "R3 corr_go" : "R4 corr_go", int'(corr_go), int'(n == go_cyc));
      er = 1'b0; ew = 1'b0; ai = 0;
      for (int e = 0; e < 4; e++) begin
        if (rd_cyc[e] == n) er = 1'b1;
        if (wr_cyc[e] == n) begin ew = 1'b1; ai = e; end
      end
      chk(buf_rd == er, "R7 buf_rd", int'(buf_rd), int'(er));
      chk(buf_wr == ew, "R8 buf_wr", int'(buf_wr), int'(ew));
      if (ew) begin
        chk(int'(buf_addr) == wa[ai], "R6 R7 buf_addr", int'(buf_addr), wa[ai]);
        chk(int'(buf_wdata) == wd[ai], "R8 buf_wdata", int'(buf_wdata), wd[ai]);
      end
      chk(done == (n == done_cyc), syn == '0 ? "R3 done" : "R9 done", int'(done), int'(n == done_cyc));
      chk(fail == (n == done_cyc && efail), "R5 fail", int'(fail), int'(n == done_cyc && efail));
      if (n == done_cyc) chk(int'(fixed_cnt) == cnt, "R9 fixed_cnt", int'(fixed_cnt), cnt);
      if (poke && n > 15) chk(!ld_valid, "R10 start ignored", int'(ld_valid), 0);
    end
    for (int i = 0; i < 512; i++)
      if (mem[i] !== mdl[i]) chk(1'b0, "R8 buffer image", int'(mem[i]), int'(mdl[i]));
    chk(1'b1, "R8 buffer image", 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ld_valid && !corr_go && !buf_rd && !buf_wr && !done && !fail, "R10 reset strobes",
        {ld_valid, corr_go, buf_rd, buf_wr, done, fail}, 0);
    chk(fixed_cnt == 3'd0, "R10 reset fixed_cnt", int'(fixed_cnt), 0);
    run_case(80'hA5C3_0F1E_2D3C_4B5A_6978, '0, 4'd0, 2'd0, 0, '0, '0, '0, '0, 1'b0);
    run_case(80'h1234_5678_9ABC_DEF0_0FF1, 40'h1, 4'd0, 2'd0, 5, '0, '0, '0, '0, 1'b0);
    run_case(80'hFFFF_0000_FFFF_0000_8001, 40'h80_0000_0000, 4'd1, 2'd0, 50, '0, '0, '0, '0, 1'b0);
    run_case(80'h0123_4567_89AB_CDEF_5A5A, 40'h3FF, 4'd2, 2'd0, 12,
             {6'h0, 10'd0, 6'h0, 10'd100}, '0, {6'h0, 10'd0, 6'h0, 10'h3A5}, '0, 1'b0);
    run_case(80'hDEAD_BEEF_CAFE_F00D_1357, 40'h5_0000, 4'd3, 2'd3, 40,
             {6'h0, 10'd3, 6'h0, 10'd519}, {6'h0, 10'd520, 6'h0, 10'd8},
             {6'h0, 10'h055, 6'h0, 10'h1FF}, {6'h0, 10'h2AA, 6'h0, 10'h0C3}, 1'b0);
    run_case(80'h2468_ACE0_1357_9BDF_0000, 40'h2_0000_0000, 4'd2, 2'd1, 0,
             {6'h0, 10'd300, 6'h0, 10'd300}, '0, {6'h0, 10'h022, 6'h0, 10'h011}, '0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule